// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes bytes from a keyboard that talks over two open-drain wires, a clock line and a data line, both driven by the keyboard. The receiver runs on a fast system clock. It passes both wires through flop synchronisers and finds each rising edge of the keyboard clock. At every rising edge it samples the data wire.

A frame takes ten rising edges. The first edge samples the start level, which must be low. The next eight edges sample the data byte, least significant bit first. The tenth edge samples a parity bit that makes the total count of ones odd. After the tenth edge the keyboard holds data low as its stop level, and the receiver ignores that level. A good byte goes into a small FIFO that the host drains through a valid/ready pair. A bad start level or a parity mismatch discards the byte, gives an error pulse, and pulses a resend request that carries the resend code. A frame that stalls mid-way is aborted by a timer.

The host may pull the data wire low to stop the keyboard from sending. While it does so, the receiver drops any partial frame and ignores clock edges.

Top module: `kbd_frame_rx`

## Requirements
- R1: A frame is decoded from ten rising edges of the synchronised keyboard clock. Edge 1 samples the start level (0). Edges 2 to 9 sample data bits 0 to 7, least significant first. Edge 10 samples parity. When the frame is good, the byte becomes readable on `rx_data_o` with `rx_valid_o` high.
- R2: Parity is odd. If the eight data bits and the parity bit hold an even number of ones, the byte is discarded and `err_parity_o` pulses high for one cycle.
- R3: If the data line is high at the first edge of a frame, the frame is rejected, `err_frame_o` pulses high for one cycle, and the receiver stays idle.
- R4: `resend_req_o` pulses for one cycle exactly when R2 or R3 fires, and `resend_code_o` is 8'hFE.
- R5: If no keyboard clock edge arrives for `TIMEOUT_CYC` system cycles after a frame has begun, the frame is aborted without delivering a byte and `err_timeout_o` pulses. Timeouts do not raise `resend_req_o`.
- R6: The start level may be held low for any length before the first rising edge; a long start phase still yields the correct byte with no error.
- R7: While `inhibit_i` is high, `data_oe_o` is high (data line pulled low), clock edges are ignored, and any partial frame is discarded without an error pulse.
- R8: Received bytes go into a FIFO of `FIFO_DEPTH` (default 4) entries and are read in arrival order. An entry leaves only on a cycle where `rx_valid_o` and `rx_ready_i` are both high. While `rx_ready_i` is low, `rx_data_o` holds.
- R9: A good byte that arrives while the FIFO is full is dropped and sets `rx_overflow_o`. The flag stays set until `ovf_clear_i` is pulsed high.
- R10: After reset, `rx_valid_o`, `rx_overflow_o`, `data_oe_o` and all pulse outputs are low.
- R11: After any completed, rejected or aborted frame, the shift and parity state are cleared, so the next frame decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Keyboard clock wire (asynchronous) |
| kb_data_i | input | 1 | Keyboard data wire (asynchronous) |
| inhibit_i | input | 1 | Host inhibit request |
| data_oe_o | output | 1 | Enable for pulling the data wire low |
| rx_data_o | output | 8 | Head byte of the FIFO |
| rx_valid_o | output | 1 | FIFO holds a byte |
| rx_ready_i | input | 1 | Consumer accepts the head byte |
| rx_overflow_o | output | 1 | Sticky drop flag |
| ovf_clear_i | input | 1 | Clears the drop flag |
| err_parity_o | output | 1 | One-cycle parity error pulse |
| err_frame_o | output | 1 | One-cycle bad start level pulse |
| err_timeout_o | output | 1 | One-cycle stalled frame pulse |
| resend_req_o | output | 1 | One-cycle resend request pulse |
| resend_code_o | output | 8 | Byte to send back on a resend request |

## Verification
Suppose a corrupted bit counter or parity accumulator is left behind after an abort. It shows up on the very next frame as a wrong byte, a missing byte, or a false parity pulse, about ten keyboard clock periods later. The bench therefore follows every error, timeout and inhibit case with a good frame. A FIFO pointer fault shows up as out-of-order or repeated bytes once the consumer stalls and then resumes. A wrong stall or wrong overflow handling shows up at the first pop after the FIFO has filled.

// File: rtl/kbdrx_pkg.sv
package kbdrx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_PAR  = 2'd2
    } rx_phase_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/kbdrx_sync.sv
module kbdrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_clk_i,
    input  logic kb_data_i,
    output logic clk_s_o,
    output logic data_s_o,
    output logic rise_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_w;
    logic [LINES-1:0] sync_w;
    logic             prev_d, prev_q;

    assign raw_w = {kb_data_i, kb_clk_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_d, chain_q;
            always_comb begin
                chain_d = {chain_q[STAGES-2:0], raw_w[g]};
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= chain_d;
            end
            assign sync_w[g] = chain_q[STAGES-1];
        end
    endgenerate

    always_comb begin
        prev_d = sync_w[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign clk_s_o  = sync_w[0];
    assign data_s_o = sync_w[1];
    assign rise_o   = sync_w[0] & ~prev_q;

    // R1: an edge marker lasts one cycle
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/kbdrx_fsm.sv
module kbdrx_fsm
    import kbdrx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              data_i,
    input  logic              inhibit_i,
    output logic              push_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              err_par_o,
    output logic              err_frm_o,
    output logic              err_to_o,
    output logic              resend_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        rx_phase_e         phase;
        logic [CNT_W-1:0]  bitn;
        logic [BYTE_W-1:0] shift;
        logic              par;
        logic [TMR_W-1:0]  tmr;
        logic              push;
        logic [BYTE_W-1:0] byte_out;
        logic              err_par;
        logic              err_frm;
        logic              err_to;
        logic              resend;
    } fsm_state_t;

    fsm_state_t d, q;

    always_comb begin
        d         = q;
        d.push    = 1'b0;
        d.err_par = 1'b0;
        d.err_frm = 1'b0;
        d.err_to  = 1'b0;
        d.resend  = 1'b0;

        if (inhibit_i) begin
            d.phase = PH_IDLE;
            d.bitn  = '0;
            d.shift = '0;
            d.par   = 1'b0;
            d.tmr   = '0;
        end else if (rise_i) begin
            d.tmr = '0;
            unique case (q.phase)
                PH_IDLE: begin
                    d.shift = '0;
                    d.par   = 1'b0;
                    d.bitn  = '0;
                    if (!data_i) begin
                        d.phase = PH_DATA;
                    end else begin
                        d.err_frm = 1'b1;
                        d.resend  = 1'b1;
                    end
                end
                PH_DATA: begin
                    d.shift = {data_i, q.shift[BYTE_W-1:1]};
                    d.par   = q.par ^ data_i;
                    if (q.bitn == CNT_W'(BYTE_W - 1)) begin
                        d.phase = PH_PAR;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end
                PH_PAR: begin
                    if (q.par ^ data_i) begin
                        d.push     = 1'b1;
                        d.byte_out = q.shift;
                    end else begin
                        d.err_par = 1'b1;
                        d.resend  = 1'b1;
                    end
                    d.phase = PH_IDLE;
                    d.bitn  = '0;
                    d.shift = '0;
                    d.par   = 1'b0;
                end
                default: d.phase = PH_IDLE;
            endcase
        end else if (q.phase != PH_IDLE) begin
            if (q.tmr == TMR_W'(TIMEOUT_CYC - 1)) begin
                d.err_to = 1'b1;
                d.phase  = PH_IDLE;
                d.bitn   = '0;
                d.shift  = '0;
                d.par    = 1'b0;
                d.tmr    = '0;
            end else begin
                d.tmr = q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push_o    = q.push;
    assign byte_o    = q.byte_out;
    assign err_par_o = q.err_par;
    assign err_frm_o = q.err_frm;
    assign err_to_o  = q.err_to;
    assign resend_o  = q.resend;

    // R7: inhibit forces the idle phase on the next cycle
    assert_inhibit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> (q.phase == PH_IDLE));
    // R4: a resend request always accompanies a parity or start error
    assert_resend_with_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resend_o |-> (err_par_o || err_frm_o));
    // R1: a byte is only produced in answer to a keyboard clock edge
    assert_push_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(rise_i));
    // R5: an aborted frame leaves the receiver idle
    assert_timeout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_to_o |-> (q.phase == PH_IDLE));
    // R2: parity error pulse lasts one cycle
    assert_par_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_par_o |=> !err_par_o);
endmodule

// File: rtl/kbdrx_fifo.sv
module kbdrx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] rdata_o,
    input  logic             clr_i,
    output logic             ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_state_t;

    fifo_state_t d, q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_pop, do_push, full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (q.cnt == CNT_W'(DEPTH));
        do_pop  = (q.cnt != '0) && ready_i;
        do_push = push_i && !full;
        d       = q;
        if (do_push) d.wr = bump(q.wr);
        if (do_pop)  d.rd = bump(q.rd);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        if (push_i && full) d.ovf = 1'b1;
        else if (clr_i)     d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wr] <= wdata_i;
    end

    assign valid_o = (q.cnt != '0);
    assign rdata_o = mem_q[q.rd];
    assign ovf_o   = q.ovf;

    // R9: overflow flag only leaves on a clear
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);
    // R8: a pop without a push shrinks the occupancy by one
    assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !push_i) |=> (q.cnt == $past(q.cnt) - 1'b1));
    // R8: head holds while the consumer stalls
    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(rdata_o)));
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int         SYNC_STAGES = 2,
    parameter int         TIMEOUT_CYC = 100000,
    parameter int         FIFO_DEPTH  = 4,
    parameter logic [7:0] RESEND_CODE = 8'hFE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_data_i,
    input  logic       inhibit_i,
    output logic       data_oe_o,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    input  logic       rx_ready_i,
    output logic       rx_overflow_o,
    input  logic       ovf_clear_i,
    output logic       err_parity_o,
    output logic       err_frame_o,
    output logic       err_timeout_o,
    output logic       resend_req_o,
    output logic [7:0] resend_code_o
);
    import kbdrx_pkg::*;

    logic              clk_s, data_s, rise;
    logic              push;
    logic [BYTE_W-1:0] byte_w;

    kbdrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .kb_clk_i  (kb_clk_i),
        .kb_data_i (kb_data_i),
        .clk_s_o   (clk_s),
        .data_s_o  (data_s),
        .rise_o    (rise)
    );

    kbdrx_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .data_i    (data_s),
        .inhibit_i (inhibit_i),
        .push_o    (push),
        .byte_o    (byte_w),
        .err_par_o (err_parity_o),
        .err_frm_o (err_frame_o),
        .err_to_o  (err_timeout_o),
        .resend_o  (resend_req_o)
    );

    kbdrx_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (byte_w),
        .ready_i (rx_ready_i),
        .valid_o (rx_valid_o),
        .rdata_o (rx_data_o),
        .clr_i   (ovf_clear_i),
        .ovf_o   (rx_overflow_o)
    );

    assign data_oe_o     = inhibit_i;
    assign resend_code_o = RESEND_CODE;

    logic unused_clk_s;
    assign unused_clk_s = clk_s;

    // R3: a start error never coincides with a delivered byte
    assert_frame_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame_o |-> !push);
endmodule

// File: tb/tb_kbd_frame_rx.sv
`timescale 1ns/1ps
module tb_kbd_frame_rx;
    localparam int TO  = 300;
    localparam int HI  = 12;
    localparam int LO  = 6;

    logic       clk = 0, rst_n = 0;
    logic       kb_clk = 1, kb_data = 1, inhibit = 0, ovf_clr = 0;
    logic       rx_ready;
    logic [7:0] rx_data, rs_code;
    logic       rx_valid, ovf, oe, e_par, e_frm, e_to, rs_req;

    int n_checks = 0, n_fail = 0;
    int c_par = 0, c_frm = 0, c_to = 0, c_rs = 0;
    logic [7:0] got [0:255];
    logic [7:0] expq[0:255];
    int got_n = 0, exp_n = 0;
    int x_par = 0, x_frm = 0, x_to = 0;
    int rdy_mode = 1;
    bit done = 0;

    always #10 clk = ~clk;

    kbd_frame_rx #(.TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_data_i(kb_data),
        .inhibit_i(inhibit), .data_oe_o(oe), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_overflow_o(ovf),
        .ovf_clear_i(ovf_clr), .err_parity_o(e_par), .err_frame_o(e_frm),
        .err_timeout_o(e_to), .resend_req_o(rs_req), .resend_code_o(rs_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic odd_bit(input logic [7:0] b);
        return ~^b;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_ready && got_n < 256) begin
                got[got_n] = rx_data;
                got_n++;
            end
            if (e_par) c_par++;
            if (e_frm) c_frm++;
            if (e_to)  c_to++;
            if (rs_req) begin
                c_rs++;
                check(rs_code == 8'hFE, "R4 resend code", rs_code, 8'hFE);
            end
        end
    end

    initial begin
        rx_ready = 1;
        forever begin
            @(posedge clk); #1;
            if (rdy_mode == 0)      rx_ready = 0;
            else if (rdy_mode == 1) rx_ready = 1;
            else                    rx_ready = 1'($urandom_range(0, 1));
        end
    end

    // nedges: how many rising edges the keyboard emits (10 = full frame)
    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_start,
                              input int start_len, input int nedges);
        logic [9:0] bits;
        bits = {odd_bit(b) ^ bad_par, b, bad_start};
        kb_data = bits[0];
        tick(start_len);
        for (int i = 0; i < nedges; i++) begin
            kb_clk  = 0;
            kb_data = bits[i];
            tick(LO);
            kb_clk = 1;
            tick(HI);
        end
        if (nedges == 10) begin
            kb_data = 0;
            tick(15);
        end
        kb_data = 1;
        tick(15);
    endtask

    task automatic compare_state(input string req);
        check(got_n == exp_n, {req, " byte count"}, got_n, exp_n);
        if (got_n == exp_n && exp_n > 0)
            check(got[exp_n-1] == expq[exp_n-1], {req, " last byte"}, got[exp_n-1], expq[exp_n-1]);
        check(c_par == x_par, {req, " parity pulses"}, c_par, x_par);
        check(c_frm == x_frm, {req, " frame pulses"}, c_frm, x_frm);
        check(c_to == x_to, {req, " timeout pulses"}, c_to, x_to);
        check(c_rs == x_par + x_frm, {req, " resend pulses"}, c_rs, x_par + x_frm);
    endtask

    task automatic good_frame(input logic [7:0] b, input string req);
        send_frame(b, 0, 0, 20, 10);
        expq[exp_n] = b; exp_n++;
        tick(10);
        compare_state(req);
    endtask

    initial begin
        void'($urandom(1234));
        tick(5);
        // R10 reset state
        check(rx_valid == 0, "R10 valid", rx_valid, 0);
        check(ovf == 0, "R10 overflow", ovf, 0);
        check(oe == 0, "R10 oe", oe, 0);
        check({e_par, e_frm, e_to, rs_req} == 0, "R10 pulses", {e_par, e_frm, e_to, rs_req}, 0);
        rst_n = 1;
        tick(5);

        // R1 directed patterns
        good_frame(8'hA5, "R1 A5");
        good_frame(8'h00, "R1 00");
        good_frame(8'hFF, "R1 FF");
        good_frame(8'h01, "R1 01");

        // R2 parity error then recovery (R11)
        send_frame(8'h3C, 1, 0, 20, 10);
        x_par++; tick(10);
        compare_state("R2 bad parity");
        good_frame(8'h3C, "R11 after parity error");

        // R3 high start level
        send_frame(8'h00, 0, 1, 20, 1);
        x_frm++; tick(10);
        compare_state("R3 bad start");
        good_frame(8'h5A, "R11 after start error");

        // R5 stalled frame
        send_frame(8'h77, 0, 0, 20, 4);
        tick(TO + 20);
        x_to++;
        compare_state("R5 timeout");
        good_frame(8'h81, "R11 after timeout");

        // R6 long start phase
        send_frame(8'hC3, 0, 0, 2000, 10);
        expq[exp_n] = 8'hC3; exp_n++;
        tick(10);
        compare_state("R6 long start");

        // R7 inhibit
        send_frame(8'h96, 0, 0, 20, 4);
        inhibit = 1;
        tick(2);
        check(oe == 1, "R7 oe while inhibited", oe, 1);
        send_frame(8'h69, 0, 0, 20, 10);
        inhibit = 0;
        tick(5);
        check(oe == 0, "R7 oe released", oe, 0);
        compare_state("R7 inhibited frames ignored");
        good_frame(8'h42, "R11 after inhibit");

        // R8/R9 stall, fill, overflow
        rdy_mode = 0;
        tick(2);
        for (int k = 0; k < 5; k++) begin
            send_frame(8'h10 + 8'(k), 0, 0, 20, 10);
            if (k < 4) begin expq[exp_n] = 8'h10 + 8'(k); exp_n++; end
        end
        tick(5);
        check(ovf == 1, "R9 overflow set", ovf, 1);
        check(rx_valid == 1 && rx_data == 8'h10, "R8 head held", rx_data, 8'h10);
        rdy_mode = 1;
        tick(10);
        compare_state("R8 drain in order");
        for (int k = 0; k < 4; k++)
            check(got[exp_n-4+k] == 8'h10 + 8'(k), "R8 order", got[exp_n-4+k], 8'h10 + 8'(k));
        check(ovf == 1, "R9 overflow sticky", ovf, 1);
        ovf_clr = 1; tick(1); ovf_clr = 0; tick(1);
        check(ovf == 0, "R9 overflow cleared", ovf, 0);

        // random frames with random consumer
        rdy_mode = 2;
        for (int k = 0; k < 40; k++) begin
            logic [7:0] b;
            bit bp;
            b  = 8'($urandom);
            bp = ($urandom_range(0, 3) == 0);
            send_frame(b, bp, 0, 10 + $urandom_range(0, 40), 10);
            if (bp) x_par++;
            else begin expq[exp_n] = b; exp_n++; end
            tick(10);
            compare_state(bp ? "R2 random" : "R1 random");
        end
        rdy_mode = 1;
        tick(10);
        for (int k = 0; k < exp_n; k++)
            if (got[k] != expq[k]) check(0, "R8 sequence", got[k], expq[k]);
        check(ovf == 0, "R9 no overflow in random run", ovf, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule